// File: doc/BRIEF.md
# Address Translation Unit with Single-Level Table Walk

This block translates 32-bit virtual addresses into physical addresses for one requester. Each address is split into a 4 KiB page offset, which passes through unchanged, and a 20-bit virtual page number. The page number is looked up in a small fully associative translation cache. On a hit, the cached physical page number is joined to the offset, and the translation is returned in the same cycle.

On a miss, a walker fetches one 32-bit page table entry from memory. It uses a plain request/response port, and the entry address is the table base input plus four times the page number. A valid entry is written into the cache in round-robin order and the lookup is then retried. An invalid entry ends the request with a page fault. Permission bits in the entry are checked against the access kind (instruction fetch, data read or data write) and raise a permission fault when the kind is not allowed. A permitted write to a clean cached entry marks it dirty, and the dirty state of the translating entry is reported beside the address. A flush input invalidates the whole cache. While a walk is in progress the requester holds its request stable and waits for ready.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, while the walker is idle, `ready_o` is high in the same cycle as the request and `paddr_o` is {entry bits [31:12], `req_vaddr_i[11:0]`}. No memory request is made.
- R2: On a miss, `mem_req_o` rises in the next cycle with `mem_addr_o` = `ptbr_i` (as sampled in the miss cycle) + `req_vaddr_i[31:12]`*4. Both stay unchanged until a cycle with `mem_rvalid_i` high, and `mem_req_o` drops after that cycle.
- R3: Entry layout: bit 0 valid, bit 1 read allowed, bit 2 write allowed, bit 3 execute allowed, bit 4 dirty, bits [31:12] physical page number. A valid response fills the cache. The retried lookup then hits one cycle after the response cycle. `ready_o` stays low while a walk is in progress.
- R4: A response with bit 0 clear gives `ready_o` and `page_fault_o` high for exactly the next cycle. Nothing is filled, so the same request walks again when it is presented again.
- R5: Access kind encoding on `req_kind_i`: 0 = fetch, which needs execute; 1 = read and 3 = reserved, which both need read; 2 = write, which needs write. On a hit whose entry forbids the kind, `perm_fault_o` is high together with `ready_o`.
- R6: `dirty_o` shows the dirty bit of the hitting entry. That bit is loaded from entry bit 4 at fill time. A permitted write hit sets it. A write refused by R5 leaves it unchanged.
- R7: Fills go to cache slots in round-robin order starting at slot 0. With 4 slots, a fifth distinct page evicts the first page filled.
- R8: `flush_i` invalidates every slot at the next clock edge and returns the fill pointer to slot 0. A fill or dirty update in the same cycle is lost.
- R9: After reset, `ready_o` and `mem_req_o` are low and every slot is invalid, so the first request walks.
- R10: Whenever `ready_o` is low, `page_fault_o`, `perm_fault_o`, `dirty_o` and `paddr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request, held until ready_o |
| req_vaddr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | Access kind (0 fetch, 1 read, 2 write, 3 read) |
| ptbr_i | input | 32 | Page table base address |
| flush_i | input | 1 | Invalidate all cached translations |
| ready_o | output | 1 | Result valid this cycle |
| paddr_o | output | 32 | Physical address |
| page_fault_o | output | 1 | Table entry was invalid |
| perm_fault_o | output | 1 | Access kind not permitted |
| dirty_o | output | 1 | Dirty state of the translating entry |
| mem_req_o | output | 1 | Table entry read request |
| mem_addr_o | output | 32 | Table entry address |
| mem_rvalid_i | input | 1 | Table entry response valid |
| mem_rdata_i | input | 32 | Table entry data |

## Verification
The hardest case to reach from the ports is a flush that lands in the same clock edge as a walk response. In that case the fill must be lost and the held request must walk a second time. The bench watches for the response strobe and raises flush one cycle wide so that it meets that edge. Eviction order is reached by filling one more distinct page than there are slots, then probing which pages still hit and which walk again. The memory latency is varied between zero and three cycles.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // entry low bits
  localparam int PTE_V = 0;
  localparam int FLAG_LSB = 1;
  localparam int FLAG_W = 4;
  // flag vector indices (entry bit = FLAG_LSB + index)
  localparam int FL_R = 0;
  localparam int FL_W = 1;
  localparam int FL_X = 2;
  localparam int FL_D = 3;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_WAIT  = 2'd1,
    WK_FAULT = 2'd2
  } walk_e;
endpackage

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  output logic              hit_o,
  output logic [PPN_W-1:0]  hit_ppn_o,
  output logic [FLAG_W-1:0] hit_flags_o,
  input  logic              set_dirty_i,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [FLAG_W-1:0] fill_flags_i
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   vpn_q   [ENTRIES];
  logic [PPN_W-1:0]   ppn_q   [ENTRIES];
  logic [FLAG_W-1:0]  flags_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;
  logic [PTR_W-1:0]   ptr_nxt;

  assign ptr_nxt = (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn_i);

    always_ff @(posedge clk_i) begin
      if (fill_i && ptr_q == PTR_W'(g)) begin
        vpn_q[g]   <= fill_vpn_i;
        ppn_q[g]   <= fill_ppn_i;
        flags_q[g] <= fill_flags_i;
      end else if (set_dirty_i && match[g]) begin
        flags_q[g][FL_D] <= 1'b1;
      end
    end
  end

  // one-hot read mux
  always_comb begin
    hit_ppn_o   = '0;
    hit_flags_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_ppn_o   = hit_ppn_o | ppn_q[i];
        hit_flags_o = hit_flags_o | flags_q[i];
      end
    end
  end
  assign hit_o = |match;

  // flush wins over a same-cycle fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (fill_i) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q        <= ptr_nxt;
    end
  end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic [1:0]        kind_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              allow_o
);
  always_comb begin
    unique case (acc_e'(kind_i))
      ACC_FETCH: allow_o = flags_i[FL_X];
      ACC_WRITE: allow_o = flags_i[FL_W];
      default:   allow_o = flags_i[FL_R];
    endcase
  end
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PA_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PA_W-1:0]  base_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PA_W-1:0]  mem_rdata_i,
  output logic             idle_o,
  output logic             fault_o,
  output logic             fill_o,
  output logic [VPN_W-1:0] fill_vpn_o
);
  localparam int PAD_W = PA_W - VPN_W - 2;

  walk_e            st_q, st_d;
  logic [VPN_W-1:0] vpn_q;
  logic [PA_W-1:0]  addr_q;
  logic             resp;

  assign resp = (st_q == WK_WAIT) && mem_rvalid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WK_IDLE:  if (start_i) st_d = WK_WAIT;
      WK_WAIT:  if (mem_rvalid_i) st_d = mem_rdata_i[PTE_V] ? WK_IDLE : WK_FAULT;
      default:  st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WK_IDLE;
      vpn_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == WK_IDLE && start_i) begin
        vpn_q  <= vpn_i;
        addr_q <= base_i + {{PAD_W{1'b0}}, vpn_i, 2'b00};
      end
    end
  end

  assign mem_req_o  = (st_q == WK_WAIT);
  assign mem_addr_o = addr_q;
  assign idle_o     = (st_q == WK_IDLE);
  assign fault_o    = (st_q == WK_FAULT);
  assign fill_o     = resp && mem_rdata_i[PTE_V];
  assign fill_vpn_o = vpn_q;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic [1:0]      req_kind_i,
  input  logic [PA_W-1:0] ptbr_i,
  input  logic            flush_i,
  output logic            ready_o,
  output logic [PA_W-1:0] paddr_o,
  output logic            page_fault_o,
  output logic            perm_fault_o,
  output logic            dirty_o,
  output logic            mem_req_o,
  output logic [PA_W-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [PA_W-1:0] mem_rdata_i
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic [VPN_W-1:0]  vpn;
  logic              hit;
  logic [PPN_W-1:0]  hit_ppn;
  logic [FLAG_W-1:0] hit_flags;
  logic              allow;
  logic              idle, wfault, fill;
  logic [VPN_W-1:0]  fill_vpn;
  logic              hit_ok;
  logic              set_dirty;

  assign vpn = req_vaddr_i[VA_W-1:OFF_W];

  tlb_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .lk_vpn_i     (vpn),
    .hit_o        (hit),
    .hit_ppn_o    (hit_ppn),
    .hit_flags_o  (hit_flags),
    .set_dirty_i  (set_dirty),
    .fill_i       (fill),
    .fill_vpn_i   (fill_vpn),
    .fill_ppn_i   (mem_rdata_i[PA_W-1:OFF_W]),
    .fill_flags_i (mem_rdata_i[FLAG_LSB+FLAG_W-1:FLAG_LSB])
  );

  tlb_perm i_perm (
    .kind_i  (req_kind_i),
    .flags_i (hit_flags),
    .allow_o (allow)
  );

  tlb_walker #(.VPN_W(VPN_W), .PA_W(PA_W)) i_walker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (idle && req_valid_i && !hit),
    .vpn_i        (vpn),
    .base_i       (ptbr_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .idle_o       (idle),
    .fault_o      (wfault),
    .fill_o       (fill),
    .fill_vpn_o   (fill_vpn)
  );

  assign hit_ok    = idle && req_valid_i && hit;
  assign set_dirty = hit_ok && (acc_e'(req_kind_i) == ACC_WRITE) && allow && !hit_flags[FL_D];

  assign ready_o      = hit_ok || wfault;
  assign paddr_o      = hit_ok ? {hit_ppn, req_vaddr_i[OFF_W-1:0]} : '0;
  assign page_fault_o = wfault;
  assign perm_fault_o = hit_ok && !allow;
  assign dirty_o      = hit_ok && hit_flags[FL_D];
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [31:0]     req_vaddr_i,
  input logic            ready_o,
  input logic [PA_W-1:0] paddr_o,
  input logic            page_fault_o,
  input logic            perm_fault_o,
  input logic            dirty_o,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_rvalid_i,
  input logic [PA_W-1:0] mem_rdata_i
);
  // R1
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !page_fault_o |-> paddr_o[OFF_W-1:0] == req_vaddr_i[OFF_W-1:0]);

  // R2
  req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o);

  // R2
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> $stable(mem_addr_o));

  // R2
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i |=> !mem_req_o);

  // R3
  walk_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);

  // R4
  invalid_faults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i && !mem_rdata_i[0] |=> page_fault_o && ready_o);

  // R4
  pf_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_fault_o |=> !page_fault_o);

  // R10
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !page_fault_o && !perm_fault_o && !dirty_o && paddr_o == '0);
endmodule

bind tlb_xlate tlb_xlate_chk #(.PA_W(PA_W), .OFF_W(OFF_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_vaddr_i  (32'(req_vaddr_i)),
  .ready_o      (ready_o),
  .paddr_o      (paddr_o),
  .page_fault_o (page_fault_o),
  .perm_fault_o (perm_fault_o),
  .dirty_o      (dirty_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_rdata_i  (mem_rdata_i)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  localparam int ENTRIES = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  kind = '0;
  logic [31:0] ptbr = 32'h0010_0000;
  logic        flush = 1'b0;
  logic        ready_o, page_fault_o, perm_fault_o, dirty_o, mem_req_o;
  logic [31:0] paddr_o, mem_addr_o;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  tlb_xlate #(.ENTRIES(ENTRIES)) i_tlb_xlate (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_vaddr_i(vaddr),
    .req_kind_i(kind), .ptbr_i(ptbr), .flush_i(flush), .ready_o(ready_o),
    .paddr_o(paddr_o), .page_fault_o(page_fault_o), .perm_fault_o(perm_fault_o),
    .dirty_o(dirty_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int walk_cnt = 0;
  bit prev_req = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // page table memory
  logic [31:0] ptmem [logic [31:0]];
  function automatic logic [31:0] pt_read(input logic [31:0] a);
    return ptmem.exists(a) ? ptmem[a] : 32'h0;
  endfunction
  task automatic set_pte(input logic [31:0] base, input logic [19:0] vpn,
                         input logic [19:0] ppn, input logic [4:0] fl);
    ptmem[base + {10'b0, vpn, 2'b00}] = {ppn, 7'b0, fl};
  endtask

  // responder
  int lat = 0;
  int rcnt = 0;
  always @(posedge clk) begin
    #2;
    if (mem_req_o && rcnt >= lat) begin
      mem_rvalid = 1'b1;
      mem_rdata  = pt_read(mem_addr_o);
      rcnt = 0;
    end else begin
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
      rcnt = mem_req_o ? rcnt + 1 : 0;
    end
  end

  // reference model
  typedef struct {bit v; bit [19:0] vpn; bit [31:0] pte; bit d;} ment_t;
  ment_t mtab [ENTRIES];
  int mptr = 0;
  int mst = 0;            // 0 idle, 1 walking, 2 fault
  bit [31:0] maddr = '0;
  bit [19:0] mvpn = '0;

  function automatic int mfind(input bit [19:0] vpn);
    for (int i = 0; i < ENTRIES; i++)
      if (mtab[i].v && mtab[i].vpn == vpn) return i;
    return -1;
  endfunction

  function automatic bit mallow(input bit [1:0] k, input bit [31:0] pte);
    case (k)
      2'd0: return pte[3];
      2'd2: return pte[2];
      default: return pte[1];
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mtab[i].v = 0;
      mptr = 0; mst = 0;
    end else begin
      int h;
      h = mfind(vaddr[31:12]);
      case (mst)
        0: if (req_valid) begin
          if (h >= 0) begin
            if (kind == 2'd2 && mallow(kind, mtab[h].pte) && !mtab[h].d) mtab[h].d = 1;
          end else begin
            mst = 1;
            maddr = ptbr + {10'b0, vaddr[31:12], 2'b00};
            mvpn = vaddr[31:12];
          end
        end
        1: if (mem_rvalid) begin
          if (mem_rdata[0]) begin
            mtab[mptr].v = 1; mtab[mptr].vpn = mvpn;
            mtab[mptr].pte = mem_rdata; mtab[mptr].d = mem_rdata[4];
            mptr = (mptr + 1) % ENTRIES;
            mst = 0;
          end else mst = 2;
        end
        default: mst = 0;
      endcase
      if (flush) begin
        for (int i = 0; i < ENTRIES; i++) mtab[i].v = 0;
        mptr = 0;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      bit e_ready, e_pf, e_perm, e_dirty, e_mreq;
      bit [31:0] e_pa;
      int h;
      e_ready = 0; e_pf = 0; e_perm = 0; e_dirty = 0; e_pa = '0;
      e_mreq = (mst == 1);
      h = mfind(vaddr[31:12]);
      if (mst == 0 && req_valid && h >= 0) begin
        e_ready = 1;
        e_pa = {mtab[h].pte[31:12], vaddr[11:0]};
        e_perm = !mallow(kind, mtab[h].pte);
        e_dirty = mtab[h].d;
      end else if (mst == 2) begin
        e_ready = 1; e_pf = 1;
      end
      chk(ready_o == e_ready, "R3", "ready", ready_o, e_ready);
      chk(mem_req_o == e_mreq, "R2", "mem_req", mem_req_o, e_mreq);
      if (e_mreq) chk(mem_addr_o == maddr, "R2", "mem_addr", mem_addr_o, maddr);
      chk(paddr_o == e_pa, e_ready ? "R1" : "R10", "paddr", paddr_o, e_pa);
      chk(page_fault_o == e_pf, e_ready ? "R4" : "R10", "page_fault", page_fault_o, e_pf);
      chk(perm_fault_o == e_perm, e_ready ? "R5" : "R10", "perm_fault", perm_fault_o, e_perm);
      chk(dirty_o == e_dirty, e_ready ? "R6" : "R10", "dirty", dirty_o, e_dirty);
      if (mem_req_o && !prev_req) walk_cnt++;
      prev_req = mem_req_o;
    end
  end

  // one request, held until ready; returns walks started and final outputs
  task automatic access(input logic [31:0] va, input logic [1:0] k, output int walks,
                        output logic [31:0] pa, output bit pf, output bit pm, output bit d);
    int w0;
    @(posedge clk); #1;
    w0 = walk_cnt;
    req_valid = 1'b1; vaddr = va; kind = k;
    forever begin
      @(negedge clk);
      #1;
      if (ready_o) break;
    end
    walks = walk_cnt - w0;
    pa = paddr_o; pf = page_fault_o; pm = perm_fault_o; d = dirty_o;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic pulse_flush();
    @(posedge clk); #1; flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w;
    logic [31:0] pa;
    bit pf, pm, d;
    set_pte(32'h0010_0000, 20'h12345, 20'hABCDE, 5'b01111);
    set_pte(32'h0010_0000, 20'h00001, 20'h00777, 5'b00011);
    set_pte(32'h0010_0000, 20'hFFFFF, 20'h00042, 5'b01001);
    for (int i = 0; i < 5; i++)
      set_pte(32'h0010_0000, 20'h00020 + 20'(i), 20'h00500 + 20'(i), 5'b10111);
    set_pte(32'h0020_0000, 20'h12345, 20'h0BEEF, 5'b00011);

    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk(ready_o == 0, "R9", "ready in reset", ready_o, 0);
    chk(mem_req_o == 0, "R9", "mem_req in reset", mem_req_o, 0);
    rst_ni = 1'b1;

    lat = 0;
    access(32'h1234_5010, 2'd1, w, pa, pf, pm, d);
    chk(w == 1, "R9", "first access walks", w, 1);
    chk(pa == 32'hABCD_E010, "R3", "paddr after fill", pa, 32'hABCDE010);
    access(32'h1234_57FF, 2'd1, w, pa, pf, pm, d);
    chk(w == 0, "R1", "hit has no walk", w, 0);
    chk(pa == 32'hABCD_E7FF, "R1", "hit paddr", pa, 32'hABCDE7FF);

    lat = 3;
    access(32'h0000_1004, 2'd1, w, pa, pf, pm, d);
    chk(pm == 0 && w == 1, "R5", "read on read-only", pm, 0);
    access(32'h0000_1008, 2'd2, w, pa, pf, pm, d);
    chk(pm == 1, "R5", "write on read-only", pm, 1);
    access(32'h0000_100C, 2'd1, w, pa, pf, pm, d);
    chk(d == 0, "R6", "refused write leaves clean", d, 0);
    access(32'hFFFF_F000, 2'd0, w, pa, pf, pm, d);
    chk(pm == 0, "R5", "fetch on exec page", pm, 0);
    access(32'hFFFF_F004, 2'd1, w, pa, pf, pm, d);
    chk(pm == 1, "R5", "read on exec-only", pm, 1);
    access(32'hFFFF_F008, 2'd3, w, pa, pf, pm, d);
    chk(pm == 1, "R5", "reserved kind acts as read", pm, 1);

    access(32'h1234_5100, 2'd2, w, pa, pf, pm, d);
    chk(d == 0 && pm == 0, "R6", "clean before write", d, 0);
    access(32'h1234_5104, 2'd1, w, pa, pf, pm, d);
    chk(d == 1, "R6", "dirty after write", d, 1);

    access(32'h0040_0000, 2'd1, w, pa, pf, pm, d);
    chk(pf == 1, "R4", "invalid entry faults", pf, 1);
    access(32'h0040_0000, 2'd1, w, pa, pf, pm, d);
    chk(w == 1 && pf == 1, "R4", "fault not cached", w, 1);

    // round robin
    lat = 1;
    pulse_flush();
    for (int i = 0; i < 5; i++) begin
      access({20'h00020 + 20'(i), 12'h0}, 2'd1, w, pa, pf, pm, d);
      chk(w == 1, "R7", "fill walk", w, 1);
    end
    access(32'h0002_2000, 2'd1, w, pa, pf, pm, d);
    chk(w == 0, "R7", "slot2 kept", w, 0);
    access(32'h0002_1000, 2'd1, w, pa, pf, pm, d);
    chk(w == 0, "R7", "slot1 kept", w, 0);
    access(32'h0002_0000, 2'd1, w, pa, pf, pm, d);
    chk(w == 1, "R7", "first page evicted", w, 1);
    access(32'h0002_1000, 2'd1, w, pa, pf, pm, d);
    chk(w == 1, "R7", "next victim evicted", w, 1);
    chk(d == 1, "R6", "dirty loaded from entry", d, 1);

    // flush
    pulse_flush();
    access(32'h0002_3000, 2'd1, w, pa, pf, pm, d);
    chk(w == 1, "R8", "walk after flush", w, 1);

    // flush meets the fill edge
    fork
      access(32'h0002_4000, 2'd1, w, pa, pf, pm, d);
      begin
        @(posedge mem_rvalid); #1; flush = 1'b1;
        @(posedge clk); #1; flush = 1'b0;
      end
    join
    chk(w == 2, "R8", "fill lost to flush", w, 2);

    // new base
    pulse_flush();
    ptbr = 32'h0020_0000;
    lat = 2;
    access(32'h1234_5ABC, 2'd1, w, pa, pf, pm, d);
    chk(pa == 32'h0BEE_FABC && w == 1, "R2", "walk from new base", pa, 32'h0BEEFABC);

    repeat (3) @(posedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule